// File: doc/BRIEF.md
# Row-Buffered Nonvolatile Data Write Controller

This block sits between a CPU bus and a small byte-addressed nonvolatile data array. The array has 128 bytes and is held here as a register model. In read mode the array behaves like plain read-only storage: a bus read returns the addressed byte in the same cycle. To change stored data, software first switches the block into latch mode. Bus writes then go into a 32-entry row buffer instead of the array. A program command then commits the buffered bytes to one row of the array. That row is taken from the address of the most recent buffered write.

A programming cycle takes a fixed, parameterised number of clock cycles. While it runs the block is busy and ignores further control and bus writes. When the cycle ends, hardware clears the latch-mode and program bits in the same cycle. Two more inputs come from the system's power manager. A wait request is acknowledged only once no cycle is running. A halt request stops a running cycle at once and throws away the buffered data.

Top module: `nvrow_ctrl`

## Requirements
- R1: After reset, both control bits read 0 (`ctl_rdata` = 2'b00). `busy` and `wait_ack` are low, and every array byte reads 8'hFF.
- R2: While the latch-mode bit is clear, a bus read returns the addressed array byte in the same cycle, and `bus_rdata_oe` is high.
- R3: While the latch-mode bit is set and no cycle runs, a bus write stores into the buffer entry selected by address bits [4:0]. At commit, only the entries written since the last buffer clear are copied; all other array bytes keep their value.
- R4: The row written by a commit is address bits [6:5] of the most recent buffered write.
- R5: A second buffered write to the same entry before commit leaves the bitwise AND of the old and new data in that entry.
- R6: A control write of 2'b11 (bit 1 = latch mode, bit 0 = program) starts a cycle. `busy` is then high for exactly PROG_CYCLES clock cycles. Both control bits fall in the same cycle that `busy` falls.
- R7: A bus read while the latch-mode bit is set leaves `bus_rdata_oe` low and `bus_rdata` at 0. A bus write while the latch-mode bit is clear changes nothing.
- R8: While a cycle runs, control writes are ignored, so the latch-mode bit cannot be cleared. Bus writes are ignored as well.
- R9: When software clears the latch-mode bit, all buffered bytes are discarded.
- R10: `wait_ack` rises one cycle after `wait_req` when idle. When `wait_req` comes during a cycle, `wait_ack` stays low until the cycle is over.
- R11: A `halt_req` during a cycle clears both control bits on the next edge. Nothing is written to the array, and the buffered bytes are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Array access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (0 when not driven) |
| bus_rdata_oe | output | 1 | Read data is being driven |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Bit 1 latch mode, bit 0 program |
| ctl_rdata | output | 2 | Current control bits, same layout |
| wait_req | input | 1 | Wait-mode request |
| halt_req | input | 1 | Halt request |
| wait_ack | output | 1 | Wait mode entered |
| busy | output | 1 | Programming cycle running |

## Verification
Some properties are checked by the assertions on every cycle:
- the program bit never stands without the latch-mode bit;
- both bits fall together;
- read data is never driven while latching;
- the timer stays in range;
- a buffer clear empties the valid mask;
- a buffered write ANDs into its entry;
- a halt aborts on the next edge.

Other behaviour can only be shown by the bench's scenarios:
- which row and which bytes reach the array;
- that unwritten bytes and other rows survive a commit;
- that the cycle length is exact;
- that the wait acknowledge arrives only after a running cycle ends.

// File: rtl/nvrow_pkg.sv
package nvrow_pkg;
  localparam int unsigned CTL_LAT = 1;
  localparam int unsigned CTL_PRG = 0;
  localparam logic [1:0]  CTL_START = 2'b11;
endpackage

// File: rtl/nvrow_latch.sv
module nvrow_latch #(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned DATA_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [IDX_W-1:0]                  wr_idx,
  input  logic [DATA_W-1:0]                 wr_data,
  input  logic                              clr,
  output logic [(1<<IDX_W)-1:0][DATA_W-1:0] lat_data,
  output logic [(1<<IDX_W)-1:0]             lat_vld
);
  localparam int unsigned N = 1 << IDX_W;

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic [DATA_W-1:0] d_q, d_nx;
    logic              v_q, v_nx, en;
    logic              hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));
    assign en  = clr || hit;
    always_comb begin
      d_nx = d_q & wr_data;
      v_nx = 1'b1;
      if (clr) begin
        d_nx = '1;
        v_nx = 1'b0;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q <= '1;
        v_q <= 1'b0;
      end else if (en) begin
        d_q <= d_nx;
        v_q <= v_nx;
      end
    end
    assign lat_data[g] = d_q;
    assign lat_vld[g]  = v_q;
  end

  assert_clr_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (lat_vld == '0));
  assert_and_merge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> (lat_data[$past(wr_idx)] == ($past(lat_data[wr_idx]) & $past(wr_data))));
endmodule

// File: rtl/nvrow_timer.sv
module nvrow_timer #(
  parameter int unsigned CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned CNT_W = $clog2(CYC + 1);
  logic [CNT_W-1:0] cnt_q, cnt_nx;

  always_comb begin
    cnt_nx = run ? cnt_q + CNT_W'(1) : '0;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end
  assign done = run && (cnt_q == CNT_W'(CYC - 1));

  assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < CNT_W'(CYC)));
endmodule

// File: rtl/nvrow_array.sv
module nvrow_array #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned DATA_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              commit,
  input  logic [ADDR_W-IDX_W-1:0]           row,
  input  logic [(1<<IDX_W)-1:0][DATA_W-1:0] lat_data,
  input  logic [(1<<IDX_W)-1:0]             lat_vld,
  input  logic [ADDR_W-1:0]                 rd_addr,
  output logic [DATA_W-1:0]                 rd_data
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned N     = 1 << IDX_W;
  localparam int unsigned ROW_W = ADDR_W - IDX_W;

  logic [DEPTH-1:0][DATA_W-1:0] cells;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    localparam int unsigned R = i / N;
    localparam int unsigned K = i % N;
    logic [DATA_W-1:0] c_q;
    logic              en;
    assign en = commit && (row == ROW_W'(R)) && lat_vld[K];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  c_q <= '1;
      else if (en) c_q <= lat_data[K];
    end
    assign cells[i] = c_q;
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/nvrow_ctrl.sv
module nvrow_ctrl
  import nvrow_pkg::*;
#(
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned IDX_W       = 5,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned PROG_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rdata_oe,
  input  logic              ctl_wr,
  input  logic [1:0]        ctl_wdata,
  output logic [1:0]        ctl_rdata,
  input  logic              wait_req,
  input  logic              halt_req,
  output logic              wait_ack,
  output logic              busy
);
  localparam int unsigned ROW_W = ADDR_W - IDX_W;
  localparam int unsigned N     = 1 << IDX_W;

  logic [1:0] rsync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  logic             lat_q, lat_nx, prg_q, prg_nx, wack_q, wack_nx;
  logic [ROW_W-1:0] row_q, row_nx;
  logic             done, clr, commit, lat_wr;
  logic [N-1:0][DATA_W-1:0] lat_data;
  logic [N-1:0]             lat_vld;
  logic [DATA_W-1:0]        arr_rd;

  assign lat_wr = bus_sel && bus_wr && lat_q && !prg_q;

  always_comb begin
    lat_nx  = lat_q;
    prg_nx  = prg_q;
    row_nx  = row_q;
    clr     = 1'b0;
    commit  = 1'b0;
    wack_nx = wait_req && !prg_q;
    if (prg_q) begin
      if (halt_req) begin
        lat_nx = 1'b0;
        prg_nx = 1'b0;
        clr    = 1'b1;
      end else if (done) begin
        commit = 1'b1;
        clr    = 1'b1;
        lat_nx = 1'b0;
        prg_nx = 1'b0;
      end
    end else if (ctl_wr) begin
      lat_nx = ctl_wdata[CTL_LAT];
      prg_nx = (ctl_wdata == CTL_START);
      if (lat_q && !ctl_wdata[CTL_LAT]) clr = 1'b1;
    end
    if (lat_wr) row_nx = bus_addr[ADDR_W-1:IDX_W];
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      lat_q  <= 1'b0;
      prg_q  <= 1'b0;
      row_q  <= '0;
      wack_q <= 1'b0;
    end else begin
      lat_q  <= lat_nx;
      prg_q  <= prg_nx;
      wack_q <= wack_nx;
      if (lat_wr) row_q <= row_nx;
    end
  end

  nvrow_latch #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst_n(rst_n_s), .wr_en(lat_wr && !clr),
    .wr_idx(bus_addr[IDX_W-1:0]), .wr_data(bus_wdata), .clr(clr),
    .lat_data(lat_data), .lat_vld(lat_vld)
  );

  nvrow_timer #(.CYC(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n_s), .run(prg_q), .done(done)
  );

  nvrow_array #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n_s), .commit(commit), .row(row_q),
    .lat_data(lat_data), .lat_vld(lat_vld), .rd_addr(bus_addr), .rd_data(arr_rd)
  );

  assign bus_rdata_oe = bus_sel && !bus_wr && !lat_q;
  assign bus_rdata    = bus_rdata_oe ? arr_rd : '0;
  assign ctl_rdata    = {lat_q, prg_q};
  assign busy         = prg_q;
  assign wait_ack     = wack_q;

  assert_prg_needs_lat_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    prg_q |-> lat_q);
  assert_bits_fall_together_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(prg_q) |-> !lat_q);
  assert_no_drive_latching_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    lat_q |-> (!bus_rdata_oe && bus_rdata == '0));
  assert_wait_deferred_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    prg_q |=> !wait_ack);
  assert_halt_aborts_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (prg_q && halt_req) |=> (!prg_q && !lat_q));
endmodule

// File: tb/sim_nvrow_ctrl.sv
module sim_nvrow_ctrl;
  localparam int PER = 10;
  localparam int PC  = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [6:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       bus_rdata_oe;
  logic       ctl_wr = 1'b0;
  logic [1:0] ctl_wdata = '0;
  logic [1:0] ctl_rdata;
  logic       wait_req = 1'b0, halt_req = 1'b0;
  logic       wait_ack, busy;

  int n_tests = 0;
  int n_fail  = 0;
  bit done_flag = 0;

  typedef struct { logic oe; logic [7:0] d; string tag; } exp_t;
  exp_t exp_q[$];

  always #(PER/2) clk = ~clk;

  nvrow_ctrl #(.PROG_CYCLES(PC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rdata_oe(bus_rdata_oe), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .wait_req(wait_req), .halt_req(halt_req),
    .wait_ack(wait_ack), .busy(busy)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a read is on the bus
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (bus_sel && !bus_wr) begin
        n_tests++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL scoreboard: unexpected read, actual %h expected none", bus_rdata);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (bus_rdata_oe !== e.oe || bus_rdata !== e.d) begin
            n_fail++;
            $display("FAIL %s: actual oe=%b data=%h expected oe=%b data=%h",
                     e.tag, bus_rdata_oe, bus_rdata, e.oe, e.d);
          end
        end
      end
    end
  end

  task automatic rd(input logic [6:0] a, input logic oe, input logic [7:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    e.oe = oe; e.d = d; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic ctl(input logic [1:0] v);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
  endtask

  initial begin
    #(PER * 100000);
    if (!done_flag) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 ctl", {6'b0, ctl_rdata}, 8'h00);
    chk("R1 busy", {7'b0, busy}, 8'h00);
    chk("R1 wait_ack", {7'b0, wait_ack}, 8'h00);
    rd(7'h00, 1'b1, 8'hFF, "R1 array erased");
    rd(7'h7F, 1'b1, 8'hFF, "R2 read top byte");

    // R7 write while not latching is ignored
    wr(7'h05, 8'h00);
    rd(7'h05, 1'b1, 8'hFF, "R7 write ignored");

    // R3 R4 R5 R7 R8 R6
    ctl(2'b10);
    chk("R9 latch bit set", {6'b0, ctl_rdata}, 8'h02);
    rd(7'h03, 1'b0, 8'h00, "R7 read undriven");
    wr(7'h22, 8'h5A);
    wr(7'h23, 8'h3C);
    wr(7'h22, 8'h0F);
    wr(7'h44, 8'h77);
    ctl(2'b11);
    chk("R6 busy after start", {7'b0, busy}, 8'h01);
    ctl(2'b00);
    chk("R8 ctl write ignored", {6'b0, ctl_rdata}, 8'h03);
    wr(7'h46, 8'h11);
    wait_idle();
    chk("R6 both bits clear", {6'b0, ctl_rdata}, 8'h00);
    rd(7'h42, 1'b1, 8'h0A, "R5 AND merge");
    rd(7'h43, 1'b1, 8'h3C, "R4 row from last write");
    rd(7'h44, 1'b1, 8'h77, "R3 committed byte");
    rd(7'h45, 1'b1, 8'hFF, "R3 unwritten byte kept");
    rd(7'h46, 1'b1, 8'hFF, "R8 bus write during cycle ignored");
    rd(7'h22, 1'b1, 8'hFF, "R4 other row untouched");

    // R9 clear of latch bit discards, R6 exact duration
    ctl(2'b10);
    wr(7'h10, 8'h00);
    ctl(2'b00);
    ctl(2'b10);
    wr(7'h11, 8'h55);
    ctl(2'b11);
    repeat (PC - 1) @(negedge clk);
    chk("R6 busy at last cycle", {7'b0, busy}, 8'h01);
    @(negedge clk);
    chk("R6 busy ended", {7'b0, busy}, 8'h00);
    chk("R6 ctl cleared", {6'b0, ctl_rdata}, 8'h00);
    rd(7'h10, 1'b1, 8'hFF, "R9 discarded byte");
    rd(7'h11, 1'b1, 8'h55, "R3 single byte commit");

    // R10 wait idle and deferred
    @(negedge clk); wait_req = 1'b1;
    @(negedge clk);
    chk("R10 idle ack", {7'b0, wait_ack}, 8'h01);
    wait_req = 1'b0;
    @(negedge clk);
    ctl(2'b10);
    wr(7'h30, 8'hC3);
    ctl(2'b11);
    wait_req = 1'b1;
    begin
      bit early = 0;
      for (int i = 0; i < 1000 && busy; i++) begin
        if (wait_ack) early = 1;
        @(negedge clk);
      end
      chk("R10 no ack during cycle", {7'b0, early}, 8'h00);
    end
    chk("R10 ack low at end edge", {7'b0, wait_ack}, 8'h00);
    @(negedge clk);
    chk("R10 ack after cycle", {7'b0, wait_ack}, 8'h01);
    wait_req = 1'b0;
    rd(7'h30, 1'b1, 8'hC3, "R10 cycle completed");

    // R11 halt aborts
    ctl(2'b10);
    wr(7'h60, 8'h12);
    ctl(2'b11);
    repeat (3) @(negedge clk);
    halt_req = 1'b1;
    @(negedge clk);
    halt_req = 1'b0;
    chk("R11 busy cleared", {7'b0, busy}, 8'h00);
    chk("R11 ctl cleared", {6'b0, ctl_rdata}, 8'h00);
    rd(7'h60, 1'b1, 8'hFF, "R11 nothing committed");
    ctl(2'b10);
    wr(7'h61, 8'hAB);
    ctl(2'b11);
    wait_idle();
    rd(7'h60, 1'b1, 8'hFF, "R11 latch discarded");
    rd(7'h61, 1'b1, 8'hAB, "R11 later commit");

    repeat (2) @(negedge clk);
    n_tests++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    done_flag = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule